// File: doc/BRIEF.md
# Balanced Ternary Ripple Adder-Subtractor

This block adds or subtracts two signed words held in balanced ternary. Each digit (a trit) takes the value minus one, zero or plus one, and each trit travels as a two-bit code. Negative numbers need no complement form. Negating a word inverts every trit. A sign-control trit scales operand B by plus one, minus one or zero before the addition. One block therefore covers A+B, A−B and a pass-through of A.

The datapath is purely combinational. A per-trit product stage conditions B. A ripple chain follows. Its lowest digit is a half-adder, its middle digits are full-adders, and its top digit depends on a parameter. With the parameter set, the top digit is a full-adder and its carry trit appears as an overflow output. With the parameter clear, the top digit is two modulo-3 sum stages, the result wraps, and the carry output stays at zero. Each full-adder chains two half-adders. Each half-adder produces a modulo-3 sum trit and a consensus carry trit. The two partial carries are merged by an "any" function: it returns the sign of the non-zero carry, and zero when the two carries are zero or opposite.

Top module: `tern_addsub`

## Requirements
- R1: Trits use the codes 2'b00 = 0, 2'b01 = +1 and 2'b10 = −1. Trit i of a word sits in bits [2i+1:2i], and a word's value is the sum of t_i·3^i. With legal inputs, no output trit ever carries 2'b11.
- R2: With sign_i = 2'b01 (+1) and CARRY_OUT = 1, the decoded value of sum_o plus carry_o·3^TRITS equals A + B exactly.
- R3: With sign_i = 2'b10 (−1) and CARRY_OUT = 1, the decoded value of sum_o plus carry_o·3^TRITS equals A − B exactly.
- R4: With sign_i = 2'b00 (0), sum_o equals a_i bit for bit and carry_o is 2'b00, whatever b_i holds.
- R5: With CARRY_OUT = 0, sum_o decodes to A ± B reduced modulo 3^TRITS into the range [−(3^TRITS−1)/2, +(3^TRITS−1)/2], and carry_o stays at 2'b00.
- R6: bad_code_o is 1 exactly when any trit of a_i, b_i or sign_i carries the code 2'b11.
- R7: Inverting every trit of both a_i and b_i, with sign_i unchanged, inverts every trit of sum_o and of carry_o.
- R8: With CARRY_OUT = 1, carry_o is 0 when the exact result fits in TRITS trits. Otherwise it takes the sign of the result. Both range edges, ±(3^TRITS−1)/2, give carry 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_i | input | 2*TRITS | Operand A, one two-bit code per trit |
| b_i | input | 2*TRITS | Operand B, one two-bit code per trit |
| sign_i | input | 2 | Scale applied to B: +1 adds, −1 subtracts, 0 drops B |
| sum_o | output | 2*TRITS | Result word |
| carry_o | output | 2 | Carry trit out of the top digit (zero when CARRY_OUT = 0) |
| bad_code_o | output | 1 | High when any input trit carries the illegal code |

## Verification
The block holds no state. A wrong carry or a wrong partial sum inside the chain therefore appears at sum_o or carry_o in the same cycle as the operands that trigger it. The fault shows as a decoded result that differs from A ± B by a multiple of a power of three. A carry merge that treats opposite carries wrongly only shows up when both half-adders of one digit produce non-zero carries of opposite sign. The exhaustive three-trit sweep covers every such digit pattern, and a nine-trit random run exercises a long ripple path under wrap-around.

// File: rtl/tern_addsub.sv
module tern_addsub #(
  parameter int TRITS     = 3,
  parameter bit CARRY_OUT = 1'b1
) (
  input  logic [2*TRITS-1:0] a_i,
  input  logic [2*TRITS-1:0] b_i,
  input  logic [1:0]         sign_i,
  output logic [2*TRITS-1:0] sum_o,
  output logic [1:0]         carry_o,
  output logic               bad_code_o
);

  localparam int W = 2 * TRITS;

  localparam logic [1:0] T_ZERO = 2'b00;
  localparam logic [1:0] T_POS  = 2'b01;
  localparam logic [1:0] T_NEG  = 2'b10;

  function automatic int tval(input logic [1:0] t);
    case (t)
      T_POS:   tval = 1;
      T_NEG:   tval = -1;
      default: tval = 0;
    endcase
  endfunction

  function automatic logic [1:0] tenc(input int v);
    if (v > 0)      tenc = T_POS;
    else if (v < 0) tenc = T_NEG;
    else            tenc = T_ZERO;
  endfunction

  function automatic logic [1:0] t_sum(input logic [1:0] x, input logic [1:0] y);
    int s;
    s = tval(x) + tval(y);
    if (s > 1)  s = s - 3;
    if (s < -1) s = s + 3;
    t_sum = tenc(s);
  endfunction

  function automatic logic [1:0] t_cons(input logic [1:0] x, input logic [1:0] y);
    t_cons = (tval(x) == tval(y)) ? tenc(tval(x)) : T_ZERO;
  endfunction

  function automatic logic [1:0] t_any(input logic [1:0] x, input logic [1:0] y);
    t_any = tenc(tval(x) + tval(y));
  endfunction

  function automatic logic [1:0] t_mul(input logic [1:0] x, input logic [1:0] y);
    t_mul = tenc(tval(x) * tval(y));
  endfunction

  logic [W-1:0] b_eff;
  logic [W-1:0] bad_vec;

  assign bad_code_o = (&sign_i) | (|bad_vec);

  genvar i;
  generate
    for (i = 0; i < TRITS; i++) begin : g_cond
      assign bad_vec[2*i]   = &a_i[2*i +: 2];
      assign bad_vec[2*i+1] = &b_i[2*i +: 2];
      assign b_eff[2*i +: 2] = t_mul(b_i[2*i +: 2], sign_i);
    end
  endgenerate

  logic [2*(TRITS-1)-1:0] cy;

  generate
    for (i = 0; i < TRITS; i++) begin : g_dig
      if (i == 0) begin : g_half
        assign sum_o[1:0] = t_sum(a_i[1:0], b_eff[1:0]);
        assign cy[1:0]    = t_cons(a_i[1:0], b_eff[1:0]);
      end else if (i < TRITS - 1 || CARRY_OUT) begin : g_full
        logic [1:0] ps, g1, g2, cin;
        assign cin = cy[2*(i-1) +: 2];
        assign ps  = t_sum(a_i[2*i +: 2], b_eff[2*i +: 2]);
        assign g1  = t_cons(a_i[2*i +: 2], b_eff[2*i +: 2]);
        assign g2  = t_cons(ps, cin);
        assign sum_o[2*i +: 2] = t_sum(ps, cin);
        if (i < TRITS - 1) begin : g_mid
          assign cy[2*i +: 2] = t_any(g1, g2);
        end else begin : g_top
          assign carry_o = t_any(g1, g2);
        end
      end else begin : g_wrap
        assign sum_o[2*i +: 2] =
          t_sum(t_sum(a_i[2*i +: 2], b_eff[2*i +: 2]), cy[2*(i-1) +: 2]);
        assign carry_o = T_ZERO;
      end
    end
  endgenerate

  always_comb begin
    if (!bad_code_o) begin
      for (int k = 0; k < TRITS; k++) begin
        p_legal_out_r1: assert (sum_o[2*k +: 2] != 2'b11)
          else $error("illegal output trit");
      end
      p_legal_carry_r1: assert (carry_o != 2'b11)
        else $error("illegal carry trit");
      if (sign_i == T_ZERO) begin
        p_drop_b_r4: assert (sum_o == a_i && carry_o == T_ZERO)
          else $error("zero sign does not pass A");
      end
      for (int k = 0; k < TRITS; k++) begin
        if (sign_i == T_POS) begin
          p_pass_b_r2: assert (b_eff[2*k +: 2] == b_i[2*k +: 2])
            else $error("B altered on add");
        end
        if (sign_i == T_NEG) begin
          p_negate_b_r3: assert (b_eff[2*k +: 2] == {b_i[2*k], b_i[2*k+1]})
            else $error("B not inverted on subtract");
        end
      end
    end
  end

endmodule

// File: tb/tern_addsub_tb_top.sv
module tern_addsub_tb_top;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [5:0]  a3, b3, s3o;
  logic [1:0]  g3, c3o;
  logic        bad3;
  logic [17:0] a9, b9, s9o;
  logic [1:0]  g9, c9o;
  logic        bad9;

  tern_addsub #(.TRITS(3), .CARRY_OUT(1'b1)) dut_i (
    .a_i(a3), .b_i(b3), .sign_i(g3),
    .sum_o(s3o), .carry_o(c3o), .bad_code_o(bad3));

  tern_addsub #(.TRITS(9), .CARRY_OUT(1'b0)) dut_min_i (
    .a_i(a9), .b_i(b9), .sign_i(g9),
    .sum_o(s9o), .carry_o(c9o), .bad_code_o(bad9));

  function automatic int dec(input logic [19:0] v, input int n);
    int r = 0, p = 1;
    for (int k = 0; k < n; k++) begin
      if (v[2*k +: 2] == 2'b01) r += p;
      else if (v[2*k +: 2] == 2'b10) r -= p;
      p *= 3;
    end
    return r;
  endfunction

  function automatic logic [19:0] enc(input int v, input int n);
    logic [19:0] r = '0;
    int x = v;
    for (int k = 0; k < n; k++) begin
      int m = ((x % 3) + 3) % 3;
      if (m == 1) begin r[2*k +: 2] = 2'b01; x = (x - 1) / 3; end
      else if (m == 2) begin r[2*k +: 2] = 2'b10; x = (x + 1) / 3; end
      else x = x / 3;
    end
    return r;
  endfunction

  function automatic logic [19:0] inv(input logic [19:0] v);
    logic [19:0] r;
    for (int k = 0; k < 10; k++) r[2*k +: 2] = {v[2*k], v[2*k+1]};
    return r;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic run3(input int va, input int vb, input int sg);
    logic [19:0] exp;
    int exact;
    @(posedge clk);
    a3 = enc(va, 3)[5:0];
    b3 = enc(vb, 3)[5:0];
    g3 = enc(sg, 1)[1:0];
    exact = va + sg * vb;
    exp = enc(exact, 4);
    @(negedge clk);
    if (sg == 0)
      chk(s3o == a3 && c3o == 2'b00, "R4", dec({14'b0, s3o}, 3), va);
    else
      chk({c3o, s3o} == exp[7:0], sg > 0 ? "R2" : "R3",
          dec({14'b0, s3o}, 3) + 27 * dec({18'b0, c3o}, 1), exact);
    chk(bad3 == 1'b0 && s3o[1:0] != 2'b11 && s3o[3:2] != 2'b11 &&
        s3o[5:4] != 2'b11 && c3o != 2'b11, "R1", int'(bad3), 0);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    a3 = '0; b3 = '0; g3 = '0; a9 = '0; b9 = '0; g9 = '0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(s3o == '0 && c3o == '0 && bad3 == 1'b0, "R1", int'(s3o), 0);

    // R2 R3 R4: exhaustive three-trit operands and all sign values
    for (int sg = -1; sg <= 1; sg++)
      for (int va = -13; va <= 13; va++)
        for (int vb = -13; vb <= 13; vb++)
          run3(va, vb, sg);

    // R8: carry at the range edges
    @(posedge clk); a3 = enc(13, 3)[5:0]; b3 = enc(0, 3)[5:0]; g3 = 2'b01;
    @(negedge clk); chk(c3o == 2'b00, "R8", int'(c3o), 0);
    @(posedge clk); a3 = enc(13, 3)[5:0]; b3 = enc(1, 3)[5:0]; g3 = 2'b01;
    @(negedge clk); chk(c3o == 2'b01 && dec({14'b0, s3o}, 3) == -13, "R8",
                        dec({14'b0, s3o}, 3), -13);
    @(posedge clk); a3 = enc(-13, 3)[5:0]; b3 = enc(1, 3)[5:0]; g3 = 2'b10;
    @(negedge clk); chk(c3o == 2'b10 && dec({14'b0, s3o}, 3) == 13, "R8",
                        dec({14'b0, s3o}, 3), 13);
    @(posedge clk); a3 = enc(-13, 3)[5:0]; b3 = enc(0, 3)[5:0]; g3 = 2'b10;
    @(negedge clk); chk(c3o == 2'b00, "R8", int'(c3o), 0);

    // R4: B ignored with zero sign
    @(posedge clk); a3 = enc(-7, 3)[5:0]; b3 = enc(13, 3)[5:0]; g3 = 2'b00;
    @(negedge clk); chk(s3o == a3 && c3o == 2'b00, "R4", dec({14'b0, s3o}, 3), -7);

    // R6: illegal codes on each input
    @(posedge clk); a3 = 6'b001100; b3 = '0; g3 = 2'b01;
    @(negedge clk); chk(bad3 == 1'b1, "R6", int'(bad3), 1);
    @(posedge clk); a3 = '0; b3 = 6'b110000; g3 = 2'b01;
    @(negedge clk); chk(bad3 == 1'b1, "R6", int'(bad3), 1);
    @(posedge clk); a3 = '0; b3 = '0; g3 = 2'b11;
    @(negedge clk); chk(bad3 == 1'b1, "R6", int'(bad3), 1);
    @(posedge clk); a3 = 6'b100110; b3 = 6'b011000; g3 = 2'b10;
    @(negedge clk); chk(bad3 == 1'b0, "R6", int'(bad3), 0);

    // R7: inverted operands give inverted result
    for (int n = 0; n < 200; n++) begin
      int va = int'($urandom % 27) - 13;
      int vb = int'($urandom % 27) - 13;
      int sg = (n % 2 == 0) ? 1 : -1;
      logic [19:0] exp = inv(enc(va + sg * vb, 4));
      @(posedge clk);
      a3 = inv(enc(va, 3))[5:0];
      b3 = inv(enc(vb, 3))[5:0];
      g3 = enc(sg, 1)[1:0];
      @(negedge clk);
      chk({c3o, s3o} == exp[7:0], "R7", int'({c3o, s3o}), int'(exp[7:0]));
    end

    // R5: nine-trit wrapping variant, random operands
    for (int n = 0; n < 2000; n++) begin
      int va = int'($urandom % 19683) - 9841;
      int vb = int'($urandom % 19683) - 9841;
      int sg = int'($urandom % 3) - 1;
      int wrapped = ((((va + sg * vb + 9841) % 19683) + 19683) % 19683) - 9841;
      @(posedge clk);
      a9 = enc(va, 9)[17:0];
      b9 = enc(vb, 9)[17:0];
      g9 = enc(sg, 1)[1:0];
      @(negedge clk);
      chk(dec({2'b0, s9o}, 9) == wrapped && c9o == 2'b00 && bad9 == 1'b0, "R5",
          dec({2'b0, s9o}, 9), wrapped);
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule